// File: doc/BRIEF.md
# Hot-Plug Slot Command Completion Controller

This block holds the slot control and slot status registers of a downstream port that may support hot-plug. Software reaches both through a small register port: it writes a 16-bit word and reads back one of three registers. A write to the slot control register can become a hot-plug command. A command sends six control bits (power controller, power indicator, attention indicator and electromechanical interlock) to the slot over a four-phase request/acknowledge handshake. When that handshake has finished, the Command Completed status bit is raised.

Two parameters set the port's capabilities: whether it is hot-plug capable, and whether it lacks command completion support. A third parameter selects how a write is judged to be a command. In compliant mode every write to slot control of a hot-plug capable port is a command. In erratum-compatible mode the block compares the stored word with the incoming one, and only a change in one of the six control bits counts as a command. A command that arrives while an earlier one is still in flight is remembered and sent once the slot interface is free.

The slot output side is a three-state machine. IDLE moves to ISSUE when a command is pending, and the data is captured at that edge. ISSUE moves to RELEASE when the acknowledge is seen. RELEASE moves back to IDLE when the acknowledge drops, which is the completion event.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: After reset the slot control register reads 0x0000, Command Completed (status bit 4) reads 0, `cmd_busy` is 0 and `slot_req` is 0.
- R2: With compliant mode on a hot-plug capable port, every write to address 0 (slot control) is a command, even when it writes the value already stored. The written word reads back from address 0.
- R3: In erratum-compatible mode a write to slot control is a command only when bits 11:6 of the new word differ from the stored word. These are interlock bit 11, power controller bit 10, power indicator bits 9:8 and attention indicator bits 7:6.
- R4: In erratum-compatible mode a write that changes only bits outside 11:6 raises neither `slot_req` nor Command Completed.
- R5: On a port that is not hot-plug capable, slot control writes are stored but never raise `slot_req`, `cmd_busy` or Command Completed.
- R6: `slot_req` rises in the second cycle after an accepted command write if the interface is idle. It then stays high until `slot_ack` is sampled high. While it is high, `slot_data[5:0]` equals bits 11:6 of the slot control word captured at issue and does not change.
- R7: Command Completed becomes 1 at the first clock edge at which `slot_ack` is sampled low after `slot_req` has dropped.
- R8: With the no-completion-support capability set, Command Completed always reads 0, although commands are still delivered to the slot.
- R9: Command Completed is cleared by writing a 1 to bit 4 of address 1 (slot status). Writing 0 there has no effect. A clear that lands on the same edge as a completion leaves the bit at 1.
- R10: `cmd_busy` is high from the edge that accepts a command until the completion edge. A slot control write made while busy is stored at once, and its command is issued after the current one, carrying the newest stored value.
- R11: Address 2 reads the capabilities: bit 0 is hot-plug capable and bit 1 is no-completion-support. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 slot control, 1 slot status, 2 capabilities |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| slot_req | output | 1 | Slot command request |
| slot_data | output | 6 | Control bits 11:6 delivered to the slot |
| slot_ack | input | 1 | Slot acknowledge |
| cmd_busy | output | 1 | A command is pending or in flight |

## Verification
The hardest case to reach from the ports is a software clear of Command Completed that falls on the same edge as a completion. The bench gets there by holding the acknowledge high after the request drops, which parks the machine in RELEASE. It then releases the acknowledge and times the status write to the edge at which the machine first sees the acknowledge low. The bench also reaches the queued-command case by stalling the acknowledge while a second write arrives. It drives four instances with different mode and capability settings in parallel from the same stimulus.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int CTRL_W      = 16;
    localparam int ADDR_W      = 2;
    localparam int FIELD_LO    = 6;
    localparam int FIELD_HI    = 11;
    localparam int FIELD_W     = FIELD_HI - FIELD_LO + 1;
    localparam int CC_BIT      = 4;
    localparam int CAP_HP_BIT  = 0;
    localparam int CAP_NCC_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CAP  = 2'd2
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_RELEASE = 2'd2
    } out_state_e;

    typedef enum logic {
        MODE_COMPLIANT = 1'b0,
        MODE_ERRATUM   = 1'b1
    } cmd_mode_e;

endpackage

// File: rtl/hp_cmd_detect.sv
module hp_cmd_detect
    import hp_slot_pkg::*;
#(
    parameter cmd_mode_e CMD_MODE   = MODE_COMPLIANT,
    parameter bit        HP_CAPABLE = 1'b1
) (
    input  logic              wr_ctrl_i,
    input  logic [CTRL_W-1:0] old_i,
    input  logic [CTRL_W-1:0] new_i,
    output logic              cmd_o
);

    logic fields_differ;

    // Only the six slot control bits take part in the comparison.
    assign fields_differ = (old_i[FIELD_HI:FIELD_LO] != new_i[FIELD_HI:FIELD_LO]);

    generate
        if (!HP_CAPABLE) begin : g_no_hotplug
            logic unused_inputs;
            assign unused_inputs = wr_ctrl_i ^ fields_differ;
            assign cmd_o = 1'b0;
        end else if (CMD_MODE == MODE_ERRATUM) begin : g_change_only
            assign cmd_o = wr_ctrl_i && fields_differ;
        end else begin : g_every_write
            logic unused_diff;
            assign unused_diff = fields_differ;
            assign cmd_o = wr_ctrl_i;
        end
    endgenerate

endmodule

// File: rtl/hp_cc_status.sv
module hp_cc_status #(
    parameter bit NO_CC_SUPPORT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic cc_o
);

    generate
        if (NO_CC_SUPPORT) begin : g_never
            logic unused_ctl;
            assign unused_ctl = set_i ^ clr_i ^ clk ^ rst_n;
            assign cc_o = 1'b0;
        end else begin : g_track
            logic cc_q;

            // A completion wins over a simultaneous software clear.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cc_q <= 1'b0;
                end else if (set_i) begin
                    cc_q <= 1'b1;
                end else if (clr_i) begin
                    cc_q <= 1'b0;
                end
            end

            assign cc_o = cc_q;

            AST_CC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(cc_q) |-> $past(set_i));                       // R7
            AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !set_i) |=> !cc_q);                       // R9
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_i |=> cc_q);                                    // R9
        end
    endgenerate

endmodule

// File: rtl/hp_slot_out_fsm.sv
module hp_slot_out_fsm
    import hp_slot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_i,
    input  logic [FIELD_W-1:0] fields_i,
    input  logic               slot_ack_i,
    output logic               slot_req_o,
    output logic [FIELD_W-1:0] slot_data_o,
    output logic               done_o,
    output logic               busy_o
);

    out_state_e         state_q, state_d;
    logic               pend_q;
    logic [FIELD_W-1:0] data_q;
    logic               launch;

    assign launch = (state_q == ST_IDLE) && pend_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pend_q)      state_d = ST_ISSUE;
            ST_ISSUE:   if (slot_ack_i)  state_d = ST_RELEASE;
            ST_RELEASE: if (!slot_ack_i) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Pending command: a new command outranks the clear on launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cmd_i) begin
            pend_q <= 1'b1;
        end else if (launch) begin
            pend_q <= 1'b0;
        end
    end

    // Snapshot of the control fields taken when a command is launched.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (launch) begin
            data_q <= fields_i;
        end
    end

    // Outputs
    always_comb begin
        slot_req_o  = (state_q == ST_ISSUE);
        slot_data_o = data_q;
        done_o      = (state_q == ST_RELEASE) && !slot_ack_i;
        busy_o      = pend_q || (state_q != ST_IDLE);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_ack_i) |=> slot_req_o);                // R6
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o |=> $stable(slot_data_o));                       // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE));                           // R7

endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl
    import hp_slot_pkg::*;
#(
    parameter cmd_mode_e CMD_MODE      = MODE_COMPLIANT,
    parameter bit        HP_CAPABLE    = 1'b1,
    parameter bit        NO_CC_SUPPORT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    output logic               slot_req,
    output logic [FIELD_W-1:0] slot_data,
    input  logic               slot_ack,
    output logic               cmd_busy
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              wr_ctrl;
    logic              clr_cc;
    logic              is_cmd;
    logic              done;
    logic              cc;

    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign clr_cc  = reg_wr && (reg_addr == REG_STAT) && reg_wdata[CC_BIT];

    // Slot control register: every write is stored whatever the mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata;
        end
    end

    hp_cmd_detect #(
        .CMD_MODE   (CMD_MODE),
        .HP_CAPABLE (HP_CAPABLE)
    ) detect_i (
        .wr_ctrl_i (wr_ctrl),
        .old_i     (ctrl_q),
        .new_i     (reg_wdata),
        .cmd_o     (is_cmd)
    );

    hp_slot_out_fsm out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (is_cmd),
        .fields_i    (ctrl_q[FIELD_HI:FIELD_LO]),
        .slot_ack_i  (slot_ack),
        .slot_req_o  (slot_req),
        .slot_data_o (slot_data),
        .done_o      (done),
        .busy_o      (cmd_busy)
    );

    hp_cc_status #(
        .NO_CC_SUPPORT (NO_CC_SUPPORT)
    ) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (done),
        .clr_i (clr_cc),
        .cc_o  (cc)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: reg_rdata = ctrl_q;
            REG_STAT: reg_rdata[CC_BIT] = cc;
            REG_CAP: begin
                reg_rdata[CAP_HP_BIT]  = HP_CAPABLE;
                reg_rdata[CAP_NCC_BIT] = NO_CC_SUPPORT;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> $past(wr_ctrl));                        // R10

    generate
        if (!HP_CAPABLE) begin : g_chk_nohp
            AST_NOHP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !cmd_busy && !slot_req);                            // R5
        end else if (CMD_MODE == MODE_ERRATUM) begin : g_chk_err
            AST_ENABLES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_ctrl && !cmd_busy &&
                 (ctrl_q[FIELD_HI:FIELD_LO] == reg_wdata[FIELD_HI:FIELD_LO]))
                |=> !cmd_busy);                                     // R4
        end else begin : g_chk_comp
            AST_EVERY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ctrl |=> cmd_busy);                              // R2
        end
    endgenerate

endmodule

// File: tb/hp_slot_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hp_slot_cmd_ctrl_tb_top;
    import hp_slot_pkg::*;

    localparam int NDUT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [NDUT-1:0] req_v, busy_v;
    logic [NDUT-1:0] ack_v = '0;
    logic [15:0] rdata_v [NDUT];
    logic [5:0]  data_v  [NDUT];
    logic stall = 1'b0;
    logic hold  = 1'b0;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    // instance 0 compliant, 1 erratum, 2 not hot-plug, 3 no completion support
    bit p_mode [NDUT] = '{1'b0, 1'b1, 1'b0, 1'b0};
    bit p_hp   [NDUT] = '{1'b1, 1'b1, 1'b0, 1'b1};
    bit p_nocc [NDUT] = '{1'b0, 1'b0, 1'b0, 1'b1};

    hp_slot_cmd_ctrl #(.CMD_MODE(MODE_COMPLIANT), .HP_CAPABLE(1'b1), .NO_CC_SUPPORT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_v[0]), .slot_req(req_v[0]), .slot_data(data_v[0]),
        .slot_ack(ack_v[0]), .cmd_busy(busy_v[0]));
    hp_slot_cmd_ctrl #(.CMD_MODE(MODE_ERRATUM), .HP_CAPABLE(1'b1), .NO_CC_SUPPORT(1'b0)) dut_err_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_v[1]), .slot_req(req_v[1]), .slot_data(data_v[1]),
        .slot_ack(ack_v[1]), .cmd_busy(busy_v[1]));
    hp_slot_cmd_ctrl #(.CMD_MODE(MODE_COMPLIANT), .HP_CAPABLE(1'b0), .NO_CC_SUPPORT(1'b0)) dut_nhp_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_v[2]), .slot_req(req_v[2]), .slot_data(data_v[2]),
        .slot_ack(ack_v[2]), .cmd_busy(busy_v[2]));
    hp_slot_cmd_ctrl #(.CMD_MODE(MODE_COMPLIANT), .HP_CAPABLE(1'b1), .NO_CC_SUPPORT(1'b1)) dut_ncc_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_v[3]), .slot_req(req_v[3]), .slot_data(data_v[3]),
        .slot_ack(ack_v[3]), .cmd_busy(busy_v[3]));

    // Behavioural reference model: phase 0 idle, 1 requesting, 2 waiting for ack low
    int m_ctrl [NDUT];
    int m_pend [NDUT];
    int m_ph   [NDUT];
    int m_data [NDUT];
    int m_cc   [NDUT];
    int rises  [NDUT];
    int last_data [NDUT];
    bit prev_req [NDUT];

    task automatic chk(input bit ok, input string tag, input int k, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s dut%0d actual 0x%0h expected 0x%0h (t=%0t)", tag, k, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        for (int k = 0; k < NDUT; k++) begin
            if (!rst_n) begin
                m_ctrl[k] = 0; m_pend[k] = 0; m_ph[k] = 0; m_data[k] = 0; m_cc[k] = 0;
                ack_v[k] <= 1'b0;
            end else begin
                bit done, issue, wr_c, is_cmd;
                done  = (m_ph[k] == 2) && !ack_v[k];
                issue = (m_ph[k] == 0) && (m_pend[k] != 0);
                if (issue) begin
                    m_data[k] = (m_ctrl[k] >> 6) & 63;
                    m_ph[k] = 1;
                end else if (m_ph[k] == 1 && ack_v[k]) begin
                    m_ph[k] = 2;
                end else if (done) begin
                    m_ph[k] = 0;
                end
                wr_c = reg_wr && (reg_addr == 2'd0);
                is_cmd = wr_c && p_hp[k] &&
                         (!p_mode[k] || (((m_ctrl[k] ^ int'(reg_wdata)) & 32'h0FC0) != 0));
                if (wr_c) m_ctrl[k] = int'(reg_wdata);
                if (is_cmd) m_pend[k] = 1;
                else if (issue) m_pend[k] = 0;
                if (done && !p_nocc[k]) m_cc[k] = 1;
                else if (reg_wr && reg_addr == 2'd1 && reg_wdata[4]) m_cc[k] = 0;
                ack_v[k] <= (req_v[k] && !stall) || (hold && ack_v[k]);
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int k = 0; k < NDUT; k++) begin
                int exp_rd;
                chk(req_v[k] == (m_ph[k] == 1), "R6 req", k, req_v[k], m_ph[k] == 1);
                chk(!req_v[k] || (int'(data_v[k]) == m_data[k]), "R6 data", k, data_v[k], m_data[k]);
                chk(busy_v[k] == ((m_pend[k] != 0) || (m_ph[k] != 0)), "R10 busy", k,
                    busy_v[k], (m_pend[k] != 0) || (m_ph[k] != 0));
                case (reg_addr)
                    2'd0: exp_rd = m_ctrl[k];
                    2'd1: exp_rd = m_cc[k] << 4;
                    2'd2: exp_rd = (int'(p_nocc[k]) << 1) | int'(p_hp[k]);
                    default: exp_rd = 0;
                endcase
                chk(int'(rdata_v[k]) == exp_rd, (reg_addr == 2'd1) ? "R7 status" : "R2 readback",
                    k, rdata_v[k], exp_rd);
                if (req_v[k] && !prev_req[k]) begin
                    rises[k]++;
                    last_data[k] = data_v[k];
                end
                prev_req[k] = req_v[k];
            end
        end
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic sel(input logic [1:0] a);
        @(negedge clk); #1;
        reg_addr = a;
        #1;
    endtask

    task automatic quiet();
        for (int i = 0; i < 200 && busy_v != '0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_rises(input int base [NDUT], input int e0, input int e1, input int e2,
                             input int e3, input string tag);
        int expv [NDUT];
        expv = '{e0, e1, e2, e3};
        for (int k = 0; k < NDUT; k++) chk(rises[k] - base[k] == expv[k], tag, k, rises[k] - base[k], expv[k]);
    endtask

    initial begin
        int snap [NDUT];
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        sel(2'd0);
        for (int k = 0; k < NDUT; k++) begin
            chk(rdata_v[k] == 16'h0, "R1 ctrl", k, rdata_v[k], 0);
            chk(!busy_v[k] && !req_v[k], "R1 idle", k, {busy_v[k], req_v[k]}, 0);
        end
        sel(2'd1);
        for (int k = 0; k < NDUT; k++) chk(rdata_v[k] == 16'h0, "R1 status", k, rdata_v[k], 0);

        // R6/R7/R5/R8: first command (power indicator 01, attention indicator 01)
        snap = rises;
        wr(2'd0, 16'h0140);
        quiet();
        chk_rises(snap, 1, 1, 0, 1, "R5 R6 command count");
        chk(last_data[0] == 6'h05, "R6 fields", 0, last_data[0], 6'h05);
        sel(2'd1);
        chk(rdata_v[0] == 16'h0010, "R7 set", 0, rdata_v[0], 16'h0010);
        chk(rdata_v[2] == 16'h0000, "R5 no status", 2, rdata_v[2], 0);
        chk(rdata_v[3] == 16'h0000, "R8 no status", 3, rdata_v[3], 0);

        // R9: writing 0 leaves the bit, writing 1 clears it
        wr(2'd1, 16'hFFEF);
        sel(2'd1);
        chk(rdata_v[0] == 16'h0010, "R9 write zero", 0, rdata_v[0], 16'h0010);
        wr(2'd1, 16'h0010);
        sel(2'd1);
        chk(rdata_v[0] == 16'h0000, "R9 clear", 0, rdata_v[0], 0);

        // R2/R3: same value again
        snap = rises;
        wr(2'd0, 16'h0140);
        quiet();
        chk_rises(snap, 1, 0, 0, 1, "R2 R3 same value");
        sel(2'd1);
        chk(rdata_v[0] == 16'h0010, "R2 status", 0, rdata_v[0], 16'h0010);
        chk(rdata_v[1] == 16'h0000, "R3 status", 1, rdata_v[1], 0);

        // R4: change only enable bits
        wr(2'd1, 16'h0010);
        snap = rises;
        wr(2'd0, 16'h717F);
        quiet();
        chk_rises(snap, 1, 0, 0, 1, "R4 enables only");
        sel(2'd1);
        chk(rdata_v[1] == 16'h0000, "R4 status", 1, rdata_v[1], 0);

        // R3: change only interlock bit 11
        snap = rises;
        wr(2'd0, 16'h797F);
        quiet();
        chk_rises(snap, 1, 1, 0, 1, "R3 interlock");
        chk(last_data[1] == 6'h25, "R3 fields", 1, last_data[1], 6'h25);

        // R10: write while busy is stored and queued
        snap = rises;
        @(negedge clk); #1 stall = 1'b1;
        wr(2'd0, 16'h0400);
        repeat (2) @(negedge clk);
        wr(2'd0, 16'h0080);
        sel(2'd0);
        chk(busy_v[0] == 1'b1, "R10 busy", 0, busy_v[0], 1);
        chk(rdata_v[0] == 16'h0080, "R10 stored", 0, rdata_v[0], 16'h0080);
        @(negedge clk); #1 stall = 1'b0;
        quiet();
        chk_rises(snap, 2, 2, 0, 2, "R10 queued");
        chk(last_data[0] == 6'h02, "R10 newest", 0, last_data[0], 6'h02);
        chk(rdata_v[2] == 16'h0080, "R5 stored", 2, rdata_v[2], 16'h0080);

        // R9: clear on the completion edge, set wins
        wr(2'd1, 16'h0010);
        @(negedge clk); #1 hold = 1'b1;
        wr(2'd0, 16'h0100);
        for (int i = 0; i < 50 && !(req_v[0] == 1'b0 && ack_v[0] == 1'b1 && busy_v[0]); i++)
            @(negedge clk);
        #1 hold = 1'b0;
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0010;
        @(negedge clk); #1;
        reg_wr = 1'b0;
        quiet();
        sel(2'd1);
        chk(rdata_v[0] == 16'h0010, "R9 set wins", 0, rdata_v[0], 16'h0010);

        // R11: capability read and write-ignore
        wr(2'd2, 16'hFFFF);
        sel(2'd2);
        chk(rdata_v[0] == 16'h0001, "R11 cap", 0, rdata_v[0], 1);
        chk(rdata_v[2] == 16'h0000, "R11 cap", 2, rdata_v[2], 0);
        chk(rdata_v[3] == 16'h0003, "R11 R8 cap", 3, rdata_v[3], 3);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule